// File: doc/BRIEF.md
# Multi-Layer Ejection Multiplexer

In a stacked chip, each layer has a horizontal router at every (X,Y) position. A packet leaves the horizontal network on whichever layer it travelled, as soon as it reaches the column of its destination. This block sits at one tile position and merges the ejection streams of all layers into the single flit port of the local processor. Because every layer feeds the same merger directly, the vertical trip from any layer is one hop.

The block has one small receive queue for each layer. The queue is filled by that layer's router under credit flow control. Each layer gets a credit pulse back in the same cycle that one of its flits is handed to the processor. A round-robin arbiter picks at most one queued flit per cycle. Once it grants the head flit of a multi-flit packet, it stays with that queue until the tail flit, so flits of different packets never interleave at the processor. The processor throttles the block with a ready signal. Each flit carries data, a virtual-channel number, and head and tail markers. A single-flit packet has both markers set.

Top module: `layer_eject_mux`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released with no new input, `pe_valid` is 0 and `lyr_credit` is all zeros. Flits that were queued before reset are discarded.
- R2: Each layer queue stores `QUEUE_DEPTH` (default 5) flits while the processor is not ready, and all of them are later delivered.
- R3: Flits from one layer reach the processor in the order that layer delivered them.
- R4: At most one flit is presented per cycle. `pe_valid` is 0 whenever every queue is empty.
- R5: Outside a packet, the grant goes round-robin among non-empty queues. The search starts at the layer one above the last granted layer, wraps from the highest index to 0, and starts at layer 0 after reset.
- R6: After a flit with head=1 and tail=0 is accepted from layer i, every flit accepted up to and including the next flit with tail=1 comes from layer i, even if other queues hold flits.
- R7: `lyr_credit[i]` is 1 for exactly the cycles in which `pe_valid` and `pe_ready` are both 1 and `pe_layer` equals i. At most one credit bit is set per cycle.
- R8: While `pe_ready` is 0, no flit is removed and no credit is returned. The presented flit stays the same as long as no new packet competes.
- R9: `pe_data`, `pe_vc`, `pe_head` and `pe_tail` equal the fields of the flit as it entered. `pe_layer` gives the index of the layer it came from.
- R10: A full queue accepts a new flit in the same cycle that one of its flits is taken. Nothing is lost and the order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lyr_valid | input | NUM_LAYERS | Per-layer flit strobe from the layer routers |
| lyr_data | input | NUM_LAYERS*DATA_W | Per-layer flit payload, layer i in slice i |
| lyr_vc | input | NUM_LAYERS*VC_W | Per-layer virtual-channel number |
| lyr_head | input | NUM_LAYERS | Per-layer head marker |
| lyr_tail | input | NUM_LAYERS | Per-layer tail marker |
| lyr_credit | output | NUM_LAYERS | One-cycle credit pulse to each layer router |
| pe_valid | output | 1 | A flit is presented to the processor |
| pe_ready | input | 1 | Processor accepts the presented flit |
| pe_data | output | DATA_W | Flit payload |
| pe_vc | output | VC_W | Flit virtual-channel number |
| pe_head | output | 1 | Flit head marker |
| pe_tail | output | 1 | Flit tail marker |
| pe_layer | output | LAYER_W | Index of the source layer |

## Verification
A single flit on one layer shows that the fields pass through and that the credit goes to the right layer. A burst of five flits held back by a low ready shows that the queue is deep enough, keeps order and does not leak credits while stalled. Single-flit packets on three layers, queued together, separate true round-robin order from fixed priority. A three-flit packet with rival single flits arriving after its head is granted separates packet locking from flit-level rotation. A push into a full queue in the same cycle as a pop shows that the slot freed by the pop is reused without loss.

// File: rtl/eject_pkg.sv
package eject_pkg;
    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_mode_e;

    function automatic int wrap_next(input int idx, input int count);
        return (idx + 1 >= count) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/eject_queue.sv
module eject_queue #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             not_empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wr;
        logic [PW-1:0]               rd;
        logic [CW-1:0]               cnt;
    } queue_state_t;

    queue_state_t st_q, st_d;
    logic do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt < CW'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data = st_q.mem[st_q.rd];
    assign not_empty = (st_q.cnt != '0);
endmodule

// File: rtl/eject_rr_arb.sv
module eject_rr_arb
    import eject_pkg::*;
#(
    parameter int N  = 4,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  nonempty,
    input  logic          accept,
    input  logic          sel_head,
    input  logic          sel_tail,
    output logic [LW-1:0] grant,
    output logic          grant_valid
);
    typedef struct packed {
        arb_mode_e     mode;
        logic [LW-1:0] owner;
        logic [LW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_q, st_d;
    logic [LW-1:0] rr_pick;
    logic          rr_found;

    always_comb begin
        rr_pick  = '0;
        rr_found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(st_q.ptr) + k) % N;
            if (!rr_found && nonempty[j]) begin
                rr_found = 1'b1;
                rr_pick  = LW'(j);
            end
        end

        if (st_q.mode == ARB_HELD) begin
            grant       = st_q.owner;
            grant_valid = nonempty[st_q.owner];
        end else begin
            grant       = rr_pick;
            grant_valid = rr_found;
        end

        st_d = st_q;
        if (accept) begin
            st_d.ptr = LW'(wrap_next(int'(grant), N));
            if (sel_tail) begin
                st_d.mode = ARB_OPEN;
            end else if (sel_head) begin
                st_d.mode  = ARB_HELD;
                st_d.owner = grant;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: ARB_OPEN, owner: '0, ptr: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/layer_eject_mux.sv
module layer_eject_mux #(
    parameter  int NUM_LAYERS  = 4,
    parameter  int QUEUE_DEPTH = 5,
    parameter  int DATA_W      = 32,
    parameter  int VC_W        = 2,
    localparam int LAYER_W     = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LAYERS-1:0]        lyr_valid,
    input  logic [NUM_LAYERS*DATA_W-1:0] lyr_data,
    input  logic [NUM_LAYERS*VC_W-1:0]   lyr_vc,
    input  logic [NUM_LAYERS-1:0]        lyr_head,
    input  logic [NUM_LAYERS-1:0]        lyr_tail,
    output logic [NUM_LAYERS-1:0]        lyr_credit,
    output logic                         pe_valid,
    input  logic                         pe_ready,
    output logic [DATA_W-1:0]            pe_data,
    output logic [VC_W-1:0]              pe_vc,
    output logic                         pe_head,
    output logic                         pe_tail,
    output logic [LAYER_W-1:0]           pe_layer
);
    localparam int FLIT_W = DATA_W + VC_W + 2;

    logic [NUM_LAYERS-1:0]             q_nonempty;
    logic [NUM_LAYERS-1:0]             q_pop;
    logic [NUM_LAYERS-1:0][FLIT_W-1:0] q_head;
    logic [LAYER_W-1:0]                grant;
    logic                              grant_valid;
    logic                              accept;
    logic [FLIT_W-1:0]                 sel_flit;

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        logic [FLIT_W-1:0] in_flit;
        assign in_flit = {lyr_head[g], lyr_tail[g],
                          lyr_vc[g*VC_W +: VC_W], lyr_data[g*DATA_W +: DATA_W]};
        assign q_pop[g] = accept && (grant == LAYER_W'(g));

        eject_queue #(
            .WIDTH (FLIT_W),
            .DEPTH (QUEUE_DEPTH)
        ) queue_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (lyr_valid[g]),
            .push_data (in_flit),
            .pop       (q_pop[g]),
            .head_data (q_head[g]),
            .not_empty (q_nonempty[g])
        );
    end

    assign sel_flit = q_head[grant];
    assign accept   = grant_valid && pe_ready;

    eject_rr_arb #(
        .N  (NUM_LAYERS),
        .LW (LAYER_W)
    ) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .nonempty    (q_nonempty),
        .accept      (accept),
        .sel_head    (sel_flit[FLIT_W-1]),
        .sel_tail    (sel_flit[FLIT_W-2]),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    assign pe_valid   = grant_valid;
    assign pe_layer   = grant;
    assign pe_head    = sel_flit[FLIT_W-1];
    assign pe_tail    = sel_flit[FLIT_W-2];
    assign pe_vc      = sel_flit[DATA_W +: VC_W];
    assign pe_data    = sel_flit[DATA_W-1:0];
    assign lyr_credit = q_pop;
endmodule

// File: rtl/eject_mux_chk.sv
module eject_mux_chk #(
    parameter int N     = 4,
    parameter int DEPTH = 5,
    parameter int LW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  lyr_valid,
    input logic [N-1:0]  lyr_credit,
    input logic          pe_valid,
    input logic          pe_ready,
    input logic          pe_head,
    input logic          pe_tail,
    input logic [LW-1:0] pe_layer
);
    localparam int CW = $clog2(DEPTH + 2);

    logic          held_q;
    logic [LW-1:0] owner_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= 1'b0;
            owner_q <= '0;
        end else if (pe_valid && pe_ready) begin
            if (pe_tail) begin
                held_q <= 1'b0;
            end else if (pe_head) begin
                held_q  <= 1'b1;
                owner_q <= pe_layer;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_occ
        logic [CW-1:0] occ_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) occ_q <= '0;
            else        occ_q <= occ_q + CW'(lyr_valid[g]) - CW'(lyr_credit[g]);
        end

        assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            lyr_valid[g] |-> (occ_q < CW'(DEPTH)) || lyr_credit[g]);

        assert_credit_for_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lyr_credit[g] |-> (occ_q != '0));
    end

    assert_one_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lyr_credit));

    assert_credit_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lyr_credit != '0) |-> (pe_valid && pe_ready && lyr_credit[pe_layer]));

    assert_stall_no_credit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_ready |-> (lyr_credit == '0));

    assert_stall_keeps_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_valid && !pe_ready) |=> pe_valid);

    assert_packet_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && pe_valid) |-> (pe_layer == owner_q));
endmodule

bind layer_eject_mux eject_mux_chk #(
    .N     (NUM_LAYERS),
    .DEPTH (QUEUE_DEPTH),
    .LW    (LAYER_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lyr_valid  (lyr_valid),
    .lyr_credit (lyr_credit),
    .pe_valid   (pe_valid),
    .pe_ready   (pe_ready),
    .pe_head    (pe_head),
    .pe_tail    (pe_tail),
    .pe_layer   (pe_layer)
);

// File: tb/layer_eject_mux_tb_top.sv
module layer_eject_mux_tb_top;
    localparam int NL = 4;
    localparam int DW = 32;
    localparam int VW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   lyr_valid = '0;
    logic [NL*DW-1:0] lyr_data = '0;
    logic [NL*VW-1:0] lyr_vc = '0;
    logic [NL-1:0]   lyr_head = '0;
    logic [NL-1:0]   lyr_tail = '0;
    logic [NL-1:0]   lyr_credit;
    logic            pe_valid;
    logic            pe_ready = 1'b0;
    logic [DW-1:0]   pe_data;
    logic [VW-1:0]   pe_vc;
    logic            pe_head;
    logic            pe_tail;
    logic [1:0]      pe_layer;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    layer_eject_mux #(
        .NUM_LAYERS  (NL),
        .QUEUE_DEPTH (5),
        .DATA_W      (DW),
        .VC_W        (VW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .lyr_valid (lyr_valid), .lyr_data (lyr_data), .lyr_vc (lyr_vc),
        .lyr_head (lyr_head), .lyr_tail (lyr_tail), .lyr_credit (lyr_credit),
        .pe_valid (pe_valid), .pe_ready (pe_ready), .pe_data (pe_data),
        .pe_vc (pe_vc), .pe_head (pe_head), .pe_tail (pe_tail), .pe_layer (pe_layer)
    );

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(int l, bit h, bit t, logic [1:0] vc, logic [31:0] d);
        @(negedge clk);
        lyr_valid[l] = 1'b1;
        lyr_head[l]  = h;
        lyr_tail[l]  = t;
        lyr_vc[l*VW +: VW] = vc;
        lyr_data[l*DW +: DW] = d;
        @(posedge clk);
        #1 lyr_valid[l] = 1'b0;
    endtask

    task automatic take(string req, int l, logic [31:0] d, logic [1:0] vc, bit h, bit t);
        @(negedge clk);
        pe_ready = 1'b1;
        #1;
        check(req, "valid", pe_valid, 1);
        check(req, "layer", pe_layer, l);
        check(req, "data", pe_data, d);
        check(req, "vc", pe_vc, vc);
        check(req, "head", pe_head, h);
        check(req, "tail", pe_tail, t);
        check("R7", "credit", lyr_credit, 1 << l);
        @(posedge clk);
        #1 pe_ready = 1'b0;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R1", "valid in reset", pe_valid, 0);
        check("R1", "credit in reset", lyr_credit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", pe_valid, 0);
    endtask

    task automatic t_single_flit;
        push(2, 1, 1, 2'd1, 32'hA200_0002);
        take("R9", 2, 32'hA200_0002, 2'd1, 1, 1);
        @(negedge clk); #1;
        check("R4", "valid when empty", pe_valid, 0);
    endtask

    task automatic t_depth_order;
        for (int i = 0; i < 5; i++) push(1, 1, 1, 2'(i), 32'h10 + i);
        @(negedge clk); #1;
        check("R8", "valid while stalled", pe_valid, 1);
        check("R8", "no credit while stalled", lyr_credit, 0);
        @(negedge clk); #1;
        check("R8", "head kept while stalled", pe_data, 32'h10);
        for (int i = 0; i < 5; i++) take("R2 R3", 1, 32'h10 + i, 2'(i), 1, 1);
    endtask

    task automatic t_round_robin;
        push(0, 1, 1, 2'd0, 32'h20);
        push(1, 1, 1, 2'd1, 32'h21);
        push(3, 1, 1, 2'd3, 32'h23);
        // last grant was layer 1, so the search starts at layer 2
        take("R5", 3, 32'h23, 2'd3, 1, 1);
        take("R5", 0, 32'h20, 2'd0, 1, 1);
        take("R5", 1, 32'h21, 2'd1, 1, 1);
    endtask

    task automatic t_packet_lock;
        push(0, 1, 0, 2'd2, 32'h30);
        push(0, 0, 0, 2'd2, 32'h31);
        push(0, 0, 1, 2'd2, 32'h32);
        take("R6", 0, 32'h30, 2'd2, 1, 0);
        push(2, 1, 1, 2'd0, 32'h40);
        push(3, 1, 1, 2'd1, 32'h41);
        @(negedge clk); #1;
        check("R8", "locked flit held", pe_data, 32'h31);
        check("R8", "no credit stalled in packet", lyr_credit, 0);
        take("R6", 0, 32'h31, 2'd2, 0, 0);
        take("R6", 0, 32'h32, 2'd2, 0, 1);
        take("R5", 2, 32'h40, 2'd0, 1, 1);
        take("R5", 3, 32'h41, 2'd1, 1, 1);
    endtask

    task automatic t_full_push_pop;
        for (int i = 0; i < 5; i++) push(1, 1, 1, 2'd3, 32'h50 + i);
        @(negedge clk);
        lyr_valid[1] = 1'b1;
        lyr_head[1] = 1'b1;
        lyr_tail[1] = 1'b1;
        lyr_vc[1*VW +: VW] = 2'd3;
        lyr_data[1*DW +: DW] = 32'h55;
        pe_ready = 1'b1;
        #1;
        check("R10", "data on full pop", pe_data, 32'h50);
        check("R10", "credit on full pop", lyr_credit, 4'b0010);
        @(posedge clk);
        #1 begin lyr_valid[1] = 1'b0; pe_ready = 1'b0; end
        for (int i = 1; i < 6; i++) take("R10", 1, 32'h50 + i, 2'd3, 1, 1);
    endtask

    task automatic t_reset_flush;
        push(3, 1, 1, 2'd0, 32'h77);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "valid during reset", pe_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", "queue flushed by reset", pe_valid, 0);
        check("R1", "credit after reset", lyr_credit, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        t_single_flit();
        t_depth_order();
        t_round_robin();
        t_packet_lock();
        t_full_push_pop();
        t_reset_flush();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule